// File: doc/BRIEF.md
# Relocatable flash sector decoder

This block sits between a host processor bus and two independent flash arrays. It turns each host address, together with the memory-space strobes, into a single chip select. The targets are one of eight main-array sectors of 32 KB, one of eight secondary-array sectors of 8 KB, the block's own control-register window, or one of several external chip-select lines. No sector has a fixed location. Software writes a base address and an enable for every sector, so each sector can be placed anywhere in the 22-bit address space. Every sector also has a write-protect flag. A write to a protected sector is never passed to the array, and a one-cycle violation pulse is raised instead.

The decode is qualified by three kinds of strobe: a boot-space strobe, an I/O-space strobe that reaches the control registers, and a group of memory-select strobes. A merge option folds the memory-select strobes into the boot strobe, so the flash stays reachable after boot through either strobe. With the merge option off, the memory-select strobes go straight to the external chip-select port.

Top module: `flash_sector_decoder`

## Requirements
- R1: Main sector i is selected when its enable is set, a flash-space strobe is active, and address bits [21:15] equal its base. The base is held zero-extended in a 15-bit field.
- R2: Secondary sector i is selected when its enable is set, a flash-space strobe is active, and address bits [21:13] equal its base.
- R3: The register window is selected when the I/O strobe is high and address bits [21:6] equal the page parameter (default 0). The register offset is address bits [5:0].
  - Sector slot s (main 0..7 = slots 0..7, secondary 0..7 = slots 8..15) has base[7:0] at offset 2s.
  - Offset 2s+1 holds {enable, base[14:8]}.
  - Offset 0x20 is the main protect mask (bit i = sector i) and 0x21 is the secondary protect mask.
  - Offset 0x22 bit 0 is the merge option.
  - A write with the window selected updates the register on the next clock edge.
- R4: Priority is fixed: register window, then main sectors by ascending index, then secondary sectors by ascending index, then external selects by ascending index. At most one select output is high.
- R5: A write to a sector whose protect bit is set leaves the array write strobe low. A read of that sector still asserts the array read strobe.
- R6: The protect-violation output is high in the cycle after a write to a protected sector, and low after any other cycle.
- R7: With the merge bit set, any memory-select strobe acts as a flash-space strobe, exactly like the boot strobe.
- R8: With the merge bit clear, the lowest active memory-select strobe drives its external select, if no higher-priority target matches. With the merge bit set, the external selects stay low.
- R9: After reset, every sector is disabled, both protect masks read 0xFF, the merge bit is 0, and the violation output is 0.
- R10: The array read and write strobes follow the host read and write strobes only while a main or secondary sector is selected.
- R11: A read with the window selected returns the addressed register on the read data output. Unmapped offsets read 0, and the output is 0 when no register read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 22 | Host address |
| wdata | input | 8 | Host write data |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| boot_stb | input | 1 | Boot-space strobe |
| io_stb | input | 1 | I/O-space strobe |
| mem_stb | input | 4 | Memory-select strobes |
| main_sel | output | 8 | One-hot main sector selects |
| sec_sel | output | 8 | One-hot secondary sector selects |
| reg_sel | output | 1 | Control-register window select |
| xcs_sel | output | 4 | External chip selects |
| arr_rd | output | 1 | Read strobe toward the arrays |
| arr_wr | output | 1 | Write strobe toward the arrays, masked by protection |
| prot_err | output | 1 | Registered write-protect violation pulse |
| rdata | output | 8 | Register read data |

## Verification
Four properties are checked on every cycle:
- the select outputs are mutually exclusive;
- the array strobes only follow the host strobes toward a selected sector;
- a violation pulse always traces back to a blocked sector write one cycle earlier;
- external selects only follow active memory-select strobes.

Other behaviours depend on programmed register contents and only the bench scenarios can show them. These include the actual base comparison, priority when a secondary sector overlaps a main sector, the effect of the merge option, and the reset-time protection of every sector.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int DATA_W   = 8;
    // Base field spans two register bytes, minus the enable bit.
    localparam int CFG_BW   = 2 * DATA_W - 1;

    typedef struct packed {
        logic              en;
        logic [CFG_BW-1:0] base;
    } sect_cfg_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_REG,
        TGT_MAIN,
        TGT_SEC,
        TGT_EXT
    } tgt_e;

    function automatic logic is_flash(input tgt_e t);
        return (t == TGT_MAIN) || (t == TGT_SEC);
    endfunction

endpackage

// File: rtl/fsd_cfg_regs.sv
module fsd_cfg_regs
    import fsd_pkg::*;
#(
    parameter int N_MAIN = 8,
    parameter int N_SEC  = 8,
    parameter int OFF_W  = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [OFF_W-1:0]               off,
    input  logic [DATA_W-1:0]              wdata,
    output sect_cfg_t [N_MAIN+N_SEC-1:0]   cfg,
    output logic [N_MAIN-1:0]              wp_main,
    output logic [N_SEC-1:0]               wp_sec,
    output logic                           merge,
    output logic [DATA_W-1:0]              rdata
);
    localparam int N_SLOT     = N_MAIN + N_SEC;
    localparam int WPM_OFF    = 2 * N_SLOT;
    localparam int WPS_OFF    = WPM_OFF + 1;
    localparam int CTRL_OFF   = WPM_OFF + 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            wp_main <= '1;
            wp_sec  <= '1;
            merge   <= 1'b0;
        end else if (we) begin
            for (int s = 0; s < N_SLOT; s++) begin
                if (off == OFF_W'(2 * s))
                    cfg[s].base[DATA_W-1:0] <= wdata;
                if (off == OFF_W'(2 * s + 1))
                    {cfg[s].en, cfg[s].base[CFG_BW-1:DATA_W]} <= wdata;
            end
            if (off == OFF_W'(WPM_OFF))  wp_main <= wdata[N_MAIN-1:0];
            if (off == OFF_W'(WPS_OFF))  wp_sec  <= wdata[N_SEC-1:0];
            if (off == OFF_W'(CTRL_OFF)) merge   <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            if (off == OFF_W'(2 * s))
                rdata = cfg[s].base[DATA_W-1:0];
            if (off == OFF_W'(2 * s + 1))
                rdata = {cfg[s].en, cfg[s].base[CFG_BW-1:DATA_W]};
        end
        if (off == OFF_W'(WPM_OFF))  rdata[N_MAIN-1:0] = wp_main;
        if (off == OFF_W'(WPS_OFF))  rdata[N_SEC-1:0]  = wp_sec;
        if (off == OFF_W'(CTRL_OFF)) rdata[0]          = merge;
    end

endmodule

// File: rtl/fsd_sector_match.sv
module fsd_sector_match
    import fsd_pkg::*;
#(
    parameter int N    = 8,
    parameter int TAGW = 7
) (
    input  logic [TAGW-1:0]     tag,
    input  logic                space,
    input  sect_cfg_t [N-1:0]   cfg,
    output logic [N-1:0]        hit
);
    // Zero-extended compare: unused upper base bits must be zero to match.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = space && cfg[i].en
                        && (cfg[i].base == CFG_BW'(tag));
    end

endmodule

// File: rtl/fsd_priority.sv
module fsd_priority
    import fsd_pkg::*;
#(
    parameter int N_MAIN = 8,
    parameter int N_SEC  = 8,
    parameter int N_XCS  = 4
) (
    input  logic              reg_hit,
    input  logic [N_MAIN-1:0] main_hit,
    input  logic [N_SEC-1:0]  sec_hit,
    input  logic [N_XCS-1:0]  xcs_req,
    output logic              reg_sel,
    output logic [N_MAIN-1:0] main_sel,
    output logic [N_SEC-1:0]  sec_sel,
    output logic [N_XCS-1:0]  xcs_sel,
    output tgt_e              target
);
    always_comb begin
        reg_sel  = 1'b0;
        main_sel = '0;
        sec_sel  = '0;
        xcs_sel  = '0;
        target   = TGT_NONE;
        if (reg_hit) begin
            reg_sel = 1'b1;
            target  = TGT_REG;
        end else if (|main_hit) begin
            main_sel = main_hit & (~main_hit + N_MAIN'(1));
            target   = TGT_MAIN;
        end else if (|sec_hit) begin
            sec_sel = sec_hit & (~sec_hit + N_SEC'(1));
            target  = TGT_SEC;
        end else if (|xcs_req) begin
            xcs_sel = xcs_req & (~xcs_req + N_XCS'(1));
            target  = TGT_EXT;
        end
    end

endmodule

// File: rtl/flash_sector_decoder.sv
module flash_sector_decoder
    import fsd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int N_MAIN   = 8,
    parameter int N_SEC    = 8,
    parameter int MAIN_SAW = 15,
    parameter int SEC_SAW  = 13,
    parameter int N_XCS    = 4,
    parameter int OFF_W    = 6,
    parameter logic [ADDR_W-OFF_W-1:0] REG_PAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    input  logic              boot_stb,
    input  logic              io_stb,
    input  logic [N_XCS-1:0]  mem_stb,
    output logic [N_MAIN-1:0] main_sel,
    output logic [N_SEC-1:0]  sec_sel,
    output logic              reg_sel,
    output logic [N_XCS-1:0]  xcs_sel,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic              prot_err,
    output logic [DATA_W-1:0] rdata
);
    localparam int N_SLOT   = N_MAIN + N_SEC;
    localparam int MAIN_TW  = ADDR_W - MAIN_SAW;
    localparam int SEC_TW   = ADDR_W - SEC_SAW;

    sect_cfg_t [N_SLOT-1:0] cfg;
    logic [N_MAIN-1:0] wp_main, main_hit;
    logic [N_SEC-1:0]  wp_sec, sec_hit;
    logic              merge, flash_space, reg_hit, blocked, flash_tgt;
    logic [N_XCS-1:0]  xcs_req;
    logic [DATA_W-1:0] cfg_rdata;
    tgt_e              target;

    assign flash_space = boot_stb | (merge & (|mem_stb));
    assign reg_hit     = io_stb && (addr[ADDR_W-1:OFF_W] == REG_PAGE);
    assign xcs_req     = merge ? '0 : mem_stb;

    fsd_cfg_regs #(.N_MAIN(N_MAIN), .N_SEC(N_SEC), .OFF_W(OFF_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (wr & reg_sel),
        .off    (addr[OFF_W-1:0]),
        .wdata  (wdata),
        .cfg    (cfg),
        .wp_main(wp_main),
        .wp_sec (wp_sec),
        .merge  (merge),
        .rdata  (cfg_rdata)
    );

    fsd_sector_match #(.N(N_MAIN), .TAGW(MAIN_TW)) u_main_match (
        .tag  (addr[ADDR_W-1:MAIN_SAW]),
        .space(flash_space),
        .cfg  (cfg[N_MAIN-1:0]),
        .hit  (main_hit)
    );

    fsd_sector_match #(.N(N_SEC), .TAGW(SEC_TW)) u_sec_match (
        .tag  (addr[ADDR_W-1:SEC_SAW]),
        .space(flash_space),
        .cfg  (cfg[N_SLOT-1:N_MAIN]),
        .hit  (sec_hit)
    );

    fsd_priority #(.N_MAIN(N_MAIN), .N_SEC(N_SEC), .N_XCS(N_XCS)) u_prio (
        .reg_hit (reg_hit),
        .main_hit(main_hit),
        .sec_hit (sec_hit),
        .xcs_req (xcs_req),
        .reg_sel (reg_sel),
        .main_sel(main_sel),
        .sec_sel (sec_sel),
        .xcs_sel (xcs_sel),
        .target  (target)
    );

    assign flash_tgt = is_flash(target);
    assign blocked   = (|(main_sel & wp_main)) | (|(sec_sel & wp_sec));
    assign arr_rd    = rd & flash_tgt;
    assign arr_wr    = wr & flash_tgt & ~blocked;
    assign rdata     = (rd & reg_sel) ? cfg_rdata : '0;

    always_ff @(posedge clk) begin
        if (rst) prot_err <= 1'b0;
        else     prot_err <= wr & flash_tgt & blocked;
    end

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
    parameter int N_MAIN = 8,
    parameter int N_SEC  = 8,
    parameter int N_XCS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd,
    input logic              wr,
    input logic              io_stb,
    input logic [N_XCS-1:0]  mem_stb,
    input logic [N_MAIN-1:0] main_sel,
    input logic [N_SEC-1:0]  sec_sel,
    input logic              reg_sel,
    input logic [N_XCS-1:0]  xcs_sel,
    input logic              arr_rd,
    input logic              arr_wr,
    input logic              prot_err
);
    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_sel, main_sel, sec_sel, xcs_sel}));

    // R10
    wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        arr_wr |-> (wr && ((|main_sel) || (|sec_sel))));

    // R10
    rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        arr_rd |-> (rd && ((|main_sel) || (|sec_sel))));

    // R6
    prot_origin_chk: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> $past(wr && ((|main_sel) || (|sec_sel)) && !arr_wr));

    // R5
    allowed_write_chk: assert property (@(posedge clk) disable iff (rst)
        arr_wr |=> !prot_err);

    // R3
    reg_space_chk: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> io_stb);

    // R8
    ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (xcs_sel & ~mem_stb) == '0);

endmodule

bind flash_sector_decoder fsd_checker #(
    .N_MAIN(N_MAIN), .N_SEC(N_SEC), .N_XCS(N_XCS)
) u_fsd_chk (
    .clk     (clk),
    .rst     (rst),
    .rd      (rd),
    .wr      (wr),
    .io_stb  (io_stb),
    .mem_stb (mem_stb),
    .main_sel(main_sel),
    .sec_sel (sec_sel),
    .reg_sel (reg_sel),
    .xcs_sel (xcs_sel),
    .arr_rd  (arr_rd),
    .arr_wr  (arr_wr),
    .prot_err(prot_err)
);

// File: tb/tb_flash_sector_decoder.sv
module tb_flash_sector_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd = 1'b0, wr = 1'b0, boot_stb = 1'b0, io_stb = 1'b0;
    logic [3:0]  mem_stb = '0;
    logic [7:0]  main_sel, sec_sel, rdata;
    logic        reg_sel, arr_rd, arr_wr, prot_err;
    logic [3:0]  xcs_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_sector_decoder dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
        .boot_stb(boot_stb), .io_stb(io_stb), .mem_stb(mem_stb),
        .main_sel(main_sel), .sec_sel(sec_sel), .reg_sel(reg_sel),
        .xcs_sel(xcs_sel), .arr_rd(arr_rd), .arr_wr(arr_wr),
        .prot_err(prot_err), .rdata(rdata)
    );

    typedef struct packed {
        logic        io;
        logic        boot;
        logic [3:0]  ms;
        logic        r;
        logic        w;
        logic [21:0] a;
        logic [7:0]  e_main;
        logic [7:0]  e_sec;
        logic        e_reg;
        logic [3:0]  e_xcs;
        logic        e_awr;
        logic        e_ard;
        logic [7:0]  e_rdata;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h000123, 8'h01, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 22'h007FFF, 8'h01, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h02A000, 8'h08, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 22'h02A000, 8'h08, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h3E6001, 8'h00, 8'h04, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h3E8000, 8'h00, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h008100, 8'h02, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h00A000, 8'h02, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00},
        '{1'b0, 1'b0, 4'h1, 1'b1, 1'b0, 22'h000000, 8'h00, 8'h00, 1'b0, 4'h1, 1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b0, 4'h6, 1'b1, 1'b0, 22'h000000, 8'h00, 8'h00, 1'b0, 4'h2, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 22'h000015, 8'h00, 8'h00, 1'b1, 4'h0, 1'b0, 1'b0, 8'h81},
        '{1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 22'h3E6000, 8'h00, 8'h04, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 4'h1, 1'b1, 1'b0, 22'h000000, 8'h01, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic io, input logic boot, input logic [3:0] ms,
                         input logic r, input logic w, input logic [21:0] a,
                         input logic [7:0] d);
        @(negedge clk);
        io_stb = io; boot_stb = boot; mem_stb = ms; rd = r; wr = w; addr = a; wdata = d;
        #2;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 22'h0, 8'h00);
    endtask

    task automatic reg_wr(input logic [5:0] off, input logic [7:0] d);
        drive(1'b1, 1'b0, 4'h0, 1'b0, 1'b1, {16'h0, off}, d);
    endtask

    task automatic reg_rd_chk(input string tag, input logic [5:0] off, input logic [7:0] exp);
        drive(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, {16'h0, off}, 8'h00);
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        // R9 reset state
        check("R9 prot_err after reset", prot_err, 0);
        check("R11 rdata idle", rdata, 0);
        reg_rd_chk("R9 main protect mask", 6'h20, 8'hFF);
        reg_rd_chk("R9 sec protect mask", 6'h21, 8'hFF);
        reg_rd_chk("R9 merge bit", 6'h22, 8'h00);
        drive(1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h000000, 8'h00);
        check("R9 sectors disabled main", main_sel, 0);
        check("R9 sectors disabled sec", sec_sel, 0);

        // configuration through the register window (R3)
        reg_wr(6'h00, 8'h00); reg_wr(6'h01, 8'h80);
        reg_wr(6'h02, 8'h01); reg_wr(6'h03, 8'h80);
        reg_wr(6'h06, 8'h05); reg_wr(6'h07, 8'h80);
        reg_wr(6'h14, 8'hF3); reg_wr(6'h15, 8'h81);
        reg_wr(6'h1A, 8'h04); reg_wr(6'h1B, 8'h80);
        reg_wr(6'h20, 8'h08); reg_wr(6'h21, 8'h00);
        reg_rd_chk("R3 sec2 high byte", 6'h15, 8'h81);
        reg_rd_chk("R3 main protect mask", 6'h20, 8'h08);
        reg_rd_chk("R11 unmapped offset", 6'h30, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].io, VECS[i].boot, VECS[i].ms, VECS[i].r, VECS[i].w, VECS[i].a, 8'h00);
            check($sformatf("R1 main_sel vec %0d", i), main_sel, VECS[i].e_main);
            check($sformatf("R2 sec_sel vec %0d", i), sec_sel, VECS[i].e_sec);
            check($sformatf("R3 reg_sel vec %0d", i), reg_sel, VECS[i].e_reg);
            check($sformatf("R8 xcs_sel vec %0d", i), xcs_sel, VECS[i].e_xcs);
            check($sformatf("R5 arr_wr vec %0d", i), arr_wr, VECS[i].e_awr);
            check($sformatf("R10 arr_rd vec %0d", i), arr_rd, VECS[i].e_ard);
            check($sformatf("R11 rdata vec %0d", i), rdata, VECS[i].e_rdata);
        end

        // R6 violation pulse timing
        drive(1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 22'h028000, 8'h00);
        check("R6 no pulse during write", prot_err, 0);
        idle();
        check("R6 pulse after blocked write", prot_err, 1);
        idle();
        check("R6 pulse lasts one cycle", prot_err, 0);
        drive(1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 22'h000040, 8'h00);
        check("R5 allowed write strobe", arr_wr, 1);
        idle();
        check("R6 no pulse after allowed write", prot_err, 0);

        // R4 reg window outranks main sector at the same address
        drive(1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 22'h000001, 8'h00);
        check("R4 reg wins", reg_sel, 1);
        check("R4 main masked", main_sel, 0);

        // R7 merge option
        reg_wr(6'h22, 8'h01);
        drive(1'b0, 1'b0, 4'h4, 1'b1, 1'b0, 22'h000010, 8'h00);
        check("R7 merged strobe selects main", main_sel, 8'h01);
        check("R8 no ext select when merged", xcs_sel, 0);
        drive(1'b0, 1'b0, 4'h4, 1'b1, 1'b0, 22'h3F0000, 8'h00);
        check("R8 merged unmapped ext", xcs_sel, 0);
        check("R7 merged unmapped main", main_sel, 0);

        // R1 disabling a sector
        reg_wr(6'h01, 8'h00);
        drive(1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 22'h000100, 8'h00);
        check("R1 disabled sector", main_sel, 0);

        // R9 reset restores protection
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        reg_rd_chk("R9 protect after re-reset", 6'h20, 8'hFF);
        reg_wr(6'h01, 8'h80);
        drive(1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 22'h000000, 8'h00);
        check("R9 enabled main0", main_sel, 8'h01);
        check("R5 default protect blocks", arr_wr, 0);
        idle();
        check("R6 pulse default protect", prot_err, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule